// File: doc/BRIEF.md
# Dual-Bank SFR Access Unit

This unit is the register-bank front end of a small 16-bit processor. It stores two banks of special function registers of 256 words each: a standard bank decoded at byte addresses 0xFE00–0xFFFF and an extended bank decoded at 0xF000–0xF1FF. Requests arrive as long 16-bit or indirect byte addresses, as short 8-bit word offsets applied to an implicit bank base, or as bit operations that name a short offset and a bit number. Reads are combinational on the request; writes and bit updates take effect at the next rising clock edge.

Short and bit requests land in the standard bank unless an extend window is open. The window is opened by an extend strobe carrying a count, and it lasts for exactly that many retired instructions. Long and indirect requests ignore the window. Byte writes always clear the partner byte of the addressed word. Short offsets at the top of the offset space name general-purpose registers and bypass both banks.

Top module: `sfr_bank_unit`

## Requirements
- R1: A long (`req_mode`=0) or indirect (`req_mode`=3) request selects the standard bank for addresses 0xFE00–0xFFFF and the extended bank for 0xF000–0xF1FF, using word index address[8:1], whatever the extend window state.
- R2: A short request (`req_mode`=1) with offset `req_addr[7:0]` below 0xF0 accesses word index equal to the offset (byte address base + 2 × offset) in the standard bank, or in the extended bank while `ext_active` is high.
- R3: A short byte request (`req_byte`=1) always addresses the low byte of the word: a read returns that byte zero-extended on `rd_data`, and a write stores `req_wdata[7:0]` in bits 7:0.
- R4: Any byte write stores the addressed byte and clears the other byte of that word to zero; for a long byte access, address bit 0 set selects bits 15:8.
- R5: A word write stores all 16 bits of `req_wdata`; a word read returns the stored word and a long byte read returns the addressed byte zero-extended.
- R6: An extend strobe with a count of 1 to 4 opens the window for exactly that many following `instr_retire` strobes (a retire in the same cycle as the strobe does not consume it); counts 0 and 5–7 are ignored.
- R7: A bit request (`req_mode`=2) on offsets 0x80–0xEF sets (`req_bitop`=1), clears (`req_bitop`=2) or tests (`req_bitop`=0 or 3) bit `req_bit` of that word, reporting the tested bit on `bit_result`; the bank follows the same window rule as R2.
- R8: A bit request on offsets 0x00–0x7F raises `out_of_range` and changes no register.
- R9: Short or bit offsets 0xF0–0xFF raise `gpr_hit`, give register number offset − 0xF0 on `gpr_num`, return zero data and touch neither bank, in either window state.
- R10: A long or indirect address outside both banks raises `out_of_range`, returns zero on `rd_data` and writes nothing.
- R11: Reset clears the extend window so `ext_active` reads low, immediately on assertion and after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 2 | 0 long, 1 short, 2 bit, 3 indirect |
| req_write | input | 1 | Write for long, indirect and short requests |
| req_byte | input | 1 | Byte-sized access |
| req_addr | input | 16 | Byte address, or short offset in bits 7:0 |
| req_wdata | input | 16 | Write data |
| req_bit | input | 4 | Bit number for bit requests |
| req_bitop | input | 2 | 0 test, 1 set, 2 clear, 3 test |
| ext_load | input | 1 | Extend strobe |
| ext_count | input | 3 | Extend window length |
| instr_retire | input | 1 | One instruction retired |
| rd_data | output | 16 | Read data |
| bit_result | output | 1 | Addressed bit of a bit request |
| out_of_range | output | 1 | Request hit no bank |
| gpr_hit | output | 1 | Short offset names a general-purpose register |
| gpr_num | output | 4 | General-purpose register number |
| ext_active | output | 1 | Extend window open |

## Verification
The assertions take for granted that the request inputs are stable across the rising edge at which a write lands, and that a write to a bank word is followed by at least one idle or unrelated cycle before the word's stored value is relied on by a new write to the same word. The bench honours this by driving every request on the falling edge, holding it through one rising edge and changing it only at the next falling edge, and it keeps an extend strobe and a request in separate cycles so the window count in its model changes only at known points.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [1:0] {
    ACC_LONG  = 2'd0,
    ACC_SHORT = 2'd1,
    ACC_BIT   = 2'd2,
    ACC_INDIR = 2'd3
  } acc_mode_e;

  typedef enum logic [1:0] {
    BOP_TEST  = 2'd0,
    BOP_SET   = 2'd1,
    BOP_CLR   = 2'd2,
    BOP_TEST2 = 2'd3
  } bit_op_e;

endpackage

// File: rtl/sfr_ext_ctr.sv
module sfr_ext_ctr #(
  parameter int CNT_W   = 3,
  parameter int CNT_MAX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             retire,
  output logic             active
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             load_ok;
  logic             cnt_en;

  assign load_ok = load && (load_val != '0) && (load_val <= CNT_W'(CNT_MAX));

  always_comb begin
    cnt_d = cnt_q;
    if (load_ok) begin
      cnt_d = load_val;
    end else if (retire && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign cnt_en = load_ok || (retire && (cnt_q != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign active = (cnt_q != '0);

  AST_EXT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> (cnt_q == $past(load_val))); // R6

  AST_EXT_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ok && retire && active) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6

  AST_EXT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !retire) |=> $stable(cnt_q)); // R6

  AST_EXT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_MAX)); // R6

endmodule

// File: rtl/sfr_addr_dec.sv
module sfr_addr_dec
  import sfr_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              OFF_W     = 8,
  parameter int              GPR_NUM_W = 4,
  parameter logic [15:0]     STD_BASE  = 16'hFE00,
  parameter logic [15:0]     EXT_BASE  = 16'hF000,
  parameter logic [7:0]      GPR_FIRST = 8'hF0
) (
  input  logic [1:0]           mode,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 ext_active,
  output logic                 hit_std,
  output logic                 hit_ext,
  output logic                 gpr,
  output logic [GPR_NUM_W-1:0] gpr_num,
  output logic                 oor,
  output logic [OFF_W-1:0]     idx,
  output logic                 byte_hi
);

  localparam int BYTE_AW = OFF_W + 1;

  logic [OFF_W-1:0] off;
  logic             is_long;

  assign off     = addr[OFF_W-1:0];
  assign is_long = (mode == ACC_LONG) || (mode == ACC_INDIR);

  always_comb begin
    hit_std = 1'b0;
    hit_ext = 1'b0;
    gpr     = 1'b0;
    gpr_num = '0;
    oor     = 1'b0;
    idx     = addr[BYTE_AW-1:1];
    byte_hi = addr[0];
    if (is_long) begin
      if (addr[ADDR_W-1:BYTE_AW] == STD_BASE[ADDR_W-1:BYTE_AW]) begin
        hit_std = 1'b1;
      end else if (addr[ADDR_W-1:BYTE_AW] == EXT_BASE[ADDR_W-1:BYTE_AW]) begin
        hit_ext = 1'b1;
      end else begin
        oor = 1'b1;
      end
    end else begin
      idx     = off;
      byte_hi = 1'b0;
      if (off >= GPR_FIRST[OFF_W-1:0]) begin
        gpr     = 1'b1;
        gpr_num = GPR_NUM_W'(off - GPR_FIRST[OFF_W-1:0]);
      end else if ((mode == ACC_BIT) && !off[OFF_W-1]) begin
        oor = 1'b1;
      end else if (ext_active) begin
        hit_ext = 1'b1;
      end else begin
        hit_std = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sfr_bank_mem.sv
module sfr_bank_mem #(
  parameter int WORD_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [OFF_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << OFF_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[idx] <= wdata;
    end
  end

  assign rdata = mem_q[idx];

  AST_MEM_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(idx)] == $past(wdata))); // R5

endmodule

// File: rtl/sfr_bank_unit.sv
module sfr_bank_unit
  import sfr_pkg::*;
#(
  parameter int           ADDR_W    = 16,
  parameter int           WORD_W    = 16,
  parameter int           OFF_W     = 8,
  parameter int           CNT_W     = 3,
  parameter int           CNT_MAX   = 4,
  parameter int           GPR_NUM_W = 4,
  parameter logic [15:0]  STD_BASE  = 16'hFE00,
  parameter logic [15:0]  EXT_BASE  = 16'hF000,
  parameter logic [7:0]   GPR_FIRST = 8'hF0,
  localparam int          BIT_W     = $clog2(WORD_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_mode,
  input  logic                 req_write,
  input  logic                 req_byte,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [WORD_W-1:0]    req_wdata,
  input  logic [BIT_W-1:0]     req_bit,
  input  logic [1:0]           req_bitop,
  input  logic                 ext_load,
  input  logic [CNT_W-1:0]     ext_count,
  input  logic                 instr_retire,
  output logic [WORD_W-1:0]    rd_data,
  output logic                 bit_result,
  output logic                 out_of_range,
  output logic                 gpr_hit,
  output logic [GPR_NUM_W-1:0] gpr_num,
  output logic                 ext_active
);

  localparam int BYTE_W = WORD_W / 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_i = rst_sync_q[1];

  sfr_ext_ctr #(
    .CNT_W   (CNT_W),
    .CNT_MAX (CNT_MAX)
  ) u_ext_ctr (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (ext_load),
    .load_val (ext_count),
    .retire   (instr_retire),
    .active   (ext_active)
  );

  logic                 hit_std, hit_ext, dec_gpr, dec_oor, byte_hi;
  logic [GPR_NUM_W-1:0] dec_gpr_num;
  logic [OFF_W-1:0]     idx;

  sfr_addr_dec #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .GPR_NUM_W (GPR_NUM_W),
    .STD_BASE  (STD_BASE),
    .EXT_BASE  (EXT_BASE),
    .GPR_FIRST (GPR_FIRST)
  ) u_dec (
    .mode       (req_mode),
    .addr       (req_addr),
    .ext_active (ext_active),
    .hit_std    (hit_std),
    .hit_ext    (hit_ext),
    .gpr        (dec_gpr),
    .gpr_num    (dec_gpr_num),
    .oor        (dec_oor),
    .idx        (idx),
    .byte_hi    (byte_hi)
  );

  logic [WORD_W-1:0] rd_bank [2];
  logic [1:0]        we_bank;
  logic [WORD_W-1:0] wr_word;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    sfr_bank_mem #(
      .WORD_W (WORD_W),
      .OFF_W  (OFF_W)
    ) u_mem (
      .clk   (clk),
      .rst_n (rst_n_i),
      .we    (we_bank[b]),
      .idx   (idx),
      .wdata (wr_word),
      .rdata (rd_bank[b])
    );
  end

  logic              is_bit;
  logic              bit_mod;
  logic              do_wr;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] bit_mask;

  assign is_bit   = (req_mode == ACC_BIT);
  assign bit_mod  = (req_bitop == BOP_SET) || (req_bitop == BOP_CLR);
  assign do_wr    = req_valid && (is_bit ? bit_mod : req_write);
  assign bit_mask = WORD_W'(1) << req_bit;

  always_comb begin
    rd_word = '0;
    if (hit_ext) begin
      rd_word = rd_bank[1];
    end else if (hit_std) begin
      rd_word = rd_bank[0];
    end
  end

  always_comb begin
    wr_word = req_wdata;
    if (is_bit) begin
      if (req_bitop == BOP_SET) begin
        wr_word = rd_word | bit_mask;
      end else if (req_bitop == BOP_CLR) begin
        wr_word = rd_word & ~bit_mask;
      end else begin
        wr_word = rd_word;
      end
    end else if (req_byte) begin
      if (byte_hi) begin
        wr_word = {req_wdata[BYTE_W-1:0], {BYTE_W{1'b0}}};
      end else begin
        wr_word = {{BYTE_W{1'b0}}, req_wdata[BYTE_W-1:0]};
      end
    end
  end

  assign we_bank[0] = do_wr && hit_std;
  assign we_bank[1] = do_wr && hit_ext;

  always_comb begin
    rd_data = '0;
    if (req_valid) begin
      if (req_byte && !is_bit) begin
        rd_data = byte_hi ? {{BYTE_W{1'b0}}, rd_word[WORD_W-1:BYTE_W]}
                          : {{BYTE_W{1'b0}}, rd_word[BYTE_W-1:0]};
      end else begin
        rd_data = rd_word;
      end
    end
  end

  assign bit_result   = req_valid && is_bit && rd_word[req_bit];
  assign out_of_range = req_valid && dec_oor;
  assign gpr_hit      = req_valid && dec_gpr;
  assign gpr_num      = req_valid ? dec_gpr_num : '0;

  AST_LONG_IGNORES_EXT: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && (req_mode == ACC_LONG)
     && (req_addr[ADDR_W-1:OFF_W+1] == STD_BASE[ADDR_W-1:OFF_W+1])) |-> !we_bank[1]); // R1

  AST_SHORT_FOLLOWS_EXT: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && (req_mode == ACC_SHORT) && !gpr_hit && ext_active && req_write)
      |-> (we_bank == 2'b10)); // R2

  AST_GPR_BYPASS: assert property (@(posedge clk) disable iff (!rst_n_i)
    gpr_hit |-> ((we_bank == 2'b00) && (rd_data == '0))); // R9

  AST_OOR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n_i)
    out_of_range |-> (we_bank == 2'b00)); // R10

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n_i)
    out_of_range |-> ((rd_data == '0) && !bit_result)); // R10

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0(we_bank)); // R1

endmodule

// File: tb/sfr_bank_unit_tb.sv
module sfr_bank_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_mode;
  logic        req_write;
  logic        req_byte;
  logic [15:0] req_addr;
  logic [15:0] req_wdata;
  logic [3:0]  req_bit;
  logic [1:0]  req_bitop;
  logic        ext_load;
  logic [2:0]  ext_count;
  logic        instr_retire;
  logic [15:0] rd_data;
  logic        bit_result;
  logic        out_of_range;
  logic        gpr_hit;
  logic [3:0]  gpr_num;
  logic        ext_active;

  sfr_bank_unit u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_mode     (req_mode),
    .req_write    (req_write),
    .req_byte     (req_byte),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_bit      (req_bit),
    .req_bitop    (req_bitop),
    .ext_load     (ext_load),
    .ext_count    (ext_count),
    .instr_retire (instr_retire),
    .rd_data      (rd_data),
    .bit_result   (bit_result),
    .out_of_range (out_of_range),
    .gpr_hit      (gpr_hit),
    .gpr_num      (gpr_num),
    .ext_active   (ext_active)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int          n_chk = 0;
  int          n_err = 0;
  int          mcnt  = 0;
  logic [15:0] exp_std [256];
  logic [15:0] exp_ext [256];
  logic [15:0] g_rd;
  logic        g_bit, g_oor, g_gpr, g_act;
  logic [3:0]  g_num;

  function automatic logic [15:0] pat(input int bank, input int i);
    logic [7:0] v;
    v = 8'(i);
    return (bank != 0) ? {~v, v ^ 8'h3C} : {v ^ 8'h5A, v};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // mode: 0 long, 1 short, 2 bit, 3 indirect; op: 0 test, 1 set, 2 clear
  task automatic acc(input logic [1:0] m, input logic w, input logic b,
                     input logic [15:0] a, input logic [15:0] d,
                     input logic [3:0] bs, input logic [1:0] op, input logic ret);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_write = w; req_byte = b;
    req_addr = a; req_wdata = d; req_bit = bs; req_bitop = op;
    instr_retire = ret; ext_load = 1'b0;
    #(CLK_PERIOD / 4);
    g_rd = rd_data; g_bit = bit_result; g_oor = out_of_range;
    g_gpr = gpr_hit; g_num = gpr_num; g_act = ext_active;
    if (ret && mcnt > 0) mcnt--;
  endtask

  task automatic ext_ld(input logic [2:0] n, input logic ret);
    @(negedge clk);
    req_valid = 1'b0; ext_load = 1'b1; ext_count = n; instr_retire = ret;
    if (n >= 1 && n <= 4) mcnt = int'(n);
    else if (ret && mcnt > 0) mcnt--;
    @(negedge clk);
    ext_load = 1'b0; instr_retire = 1'b0;
  endtask

  task automatic rd_long(input int bank, input int i);
    acc(2'd0, 1'b0, 1'b0, ((bank != 0) ? 16'hF000 : 16'hFE00) + 16'(2 * i),
        16'h0, 4'h0, 2'd0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'd0; req_write = 1'b0;
    req_byte = 1'b0; req_addr = '0; req_wdata = '0; req_bit = '0;
    req_bitop = '0; ext_load = 1'b0; ext_count = '0; instr_retire = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "ext_active after reset", 16'(ext_active), 16'h0);

    // fill both banks with word writes (standard via long, extended via indirect)
    for (int i = 0; i < 256; i++) begin
      acc(2'd0, 1'b1, 1'b0, 16'hFE00 + 16'(2 * i), pat(0, i), 4'h0, 2'd0, 1'b0);
      exp_std[i] = pat(0, i);
      acc(2'd3, 1'b1, 1'b0, 16'hF000 + 16'(2 * i), pat(1, i), 4'h0, 2'd0, 1'b0);
      exp_ext[i] = pat(1, i);
    end
    for (int i = 0; i < 256; i++) begin
      rd_long(0, i);
      chk("R1", "std long read", g_rd, exp_std[i]);
      chk("R5", "std long oor", 16'(g_oor), 16'h0);
      acc(2'd3, 1'b0, 1'b0, 16'hF000 + 16'(2 * i), 16'h0, 4'h0, 2'd0, 1'b0);
      chk("R1", "ext indirect read", g_rd, exp_ext[i]);
    end

    // short offsets sweep, window closed
    for (int o = 0; o < 256; o++) begin
      acc(2'd1, 1'b0, 1'b0, 16'(o), 16'h0, 4'h0, 2'd0, 1'b0);
      if (o >= 16'hF0) begin
        chk("R9", "gpr_hit", 16'(g_gpr), 16'h1);
        chk("R9", "gpr_num", 16'(g_num), 16'(o - 16'hF0));
        chk("R9", "gpr rd zero", g_rd, 16'h0);
      end else begin
        chk("R2", "short std read", g_rd, exp_std[o]);
      end
    end

    // extend window of 4: exactly four retired instructions see the extended bank
    ext_ld(3'd4, 1'b1);
    for (int k = 0; k < 6; k++) begin
      logic e_act;
      e_act = (mcnt > 0);
      acc(2'd1, 1'b0, 1'b0, 16'h20 + 16'(k), 16'h0, 4'h0, 2'd0, 1'b1);
      chk("R6", "window state", 16'(g_act), 16'(e_act));
      chk("R2", "short read in window", g_rd, e_act ? exp_ext[16'h20 + k] : exp_std[16'h20 + k]);
    end

    // long access ignores an open window; gpr still bypasses
    ext_ld(3'd2, 1'b1);
    rd_long(0, 7);
    chk("R1", "long during window", g_rd, exp_std[7]);
    chk("R6", "window open", 16'(g_act), 16'h1);
    acc(2'd1, 1'b0, 1'b0, 16'hF3, 16'h0, 4'h0, 2'd0, 1'b1);
    chk("R9", "gpr in window", 16'(g_gpr), 16'h1);
    acc(2'd1, 1'b0, 1'b0, 16'h07, 16'h0, 4'h0, 2'd0, 1'b1);
    chk("R2", "short last window slot", g_rd, exp_ext[7]);
    acc(2'd1, 1'b0, 1'b0, 16'h07, 16'h0, 4'h0, 2'd0, 1'b1);
    chk("R6", "window closed after count", 16'(g_act), 16'h0);

    // invalid counts ignored
    ext_ld(3'd0, 1'b0);
    acc(2'd1, 1'b0, 1'b0, 16'h01, 16'h0, 4'h0, 2'd0, 1'b0);
    chk("R6", "count 0 ignored", 16'(g_act), 16'h0);
    chk("R6", "count 0 read std", g_rd, exp_std[1]);
    ext_ld(3'd5, 1'b0);
    acc(2'd1, 1'b0, 1'b0, 16'h02, 16'h0, 4'h0, 2'd0, 1'b0);
    chk("R6", "count 5 ignored", 16'(g_act), 16'h0);

    // short byte reads return low byte
    for (int o = 0; o < 16; o++) begin
      acc(2'd1, 1'b0, 1'b1, 16'(o), 16'h0, 4'h0, 2'd0, 1'b0);
      chk("R3", "short byte read", g_rd, {8'h00, exp_std[o][7:0]});
    end
    // short byte write: low byte, partner cleared
    acc(2'd1, 1'b1, 1'b1, 16'h03, 16'hAB77, 4'h0, 2'd0, 1'b0);
    exp_std[3] = 16'h0077;
    rd_long(0, 3);
    chk("R3", "short byte write low", g_rd, exp_std[3]);
    // long byte write to high byte clears low
    acc(2'd0, 1'b1, 1'b1, 16'hFE00 + 16'(2 * 5) + 16'h1, 16'h12C3, 4'h0, 2'd0, 1'b0);
    exp_std[5] = 16'hC300;
    rd_long(0, 5);
    chk("R4", "long high byte write", g_rd, exp_std[5]);
    acc(2'd3, 1'b1, 1'b1, 16'hF000 + 16'(2 * 9), 16'h5566, 4'h0, 2'd0, 1'b0);
    exp_ext[9] = 16'h0066;
    acc(2'd3, 1'b0, 1'b0, 16'hF000 + 16'(2 * 9), 16'h0, 4'h0, 2'd0, 1'b0);
    chk("R4", "ext low byte write", g_rd, exp_ext[9]);
    acc(2'd0, 1'b0, 1'b1, 16'hFE00 + 16'(2 * 6) + 16'h1, 16'h0, 4'h0, 2'd0, 1'b0);
    chk("R5", "long high byte read", g_rd, {8'h00, exp_std[6][15:8]});

    // bit operations over every bit of one word
    acc(2'd0, 1'b1, 1'b0, 16'hFE00 + 16'(2 * 16'h90), 16'h0000, 4'h0, 2'd0, 1'b0);
    exp_std[16'h90] = 16'h0000;
    for (int b = 0; b < 16; b++) begin
      acc(2'd2, 1'b0, 1'b0, 16'h90, 16'h0, 4'(b), 2'd1, 1'b0);
      acc(2'd2, 1'b0, 1'b0, 16'h90, 16'h0, 4'(b), 2'd0, 1'b0);
      chk("R7", "test set bit", 16'(g_bit), 16'h1);
      acc(2'd2, 1'b0, 1'b0, 16'h90, 16'h0, 4'((b + 1) % 16), 2'd3, 1'b0);
      chk("R7", "test neighbour", 16'(g_bit), 16'h0);
      rd_long(0, 16'h90);
      chk("R7", "word after set", g_rd, 16'h1 << b);
      acc(2'd2, 1'b0, 1'b0, 16'h90, 16'h0, 4'(b), 2'd2, 1'b0);
      rd_long(0, 16'h90);
      chk("R7", "word after clear", g_rd, 16'h0);
    end
    ext_ld(3'd2, 1'b1);
    acc(2'd2, 1'b0, 1'b0, 16'h85, 16'h0, 4'd3, 2'd1, 1'b1);
    exp_ext[16'h85] = exp_ext[16'h85] | 16'h0008;
    acc(2'd3, 1'b0, 1'b0, 16'hF000 + 16'(2 * 16'h85), 16'h0, 4'h0, 2'd0, 1'b0);
    chk("R7", "ext bit set in window", g_rd, exp_ext[16'h85]);
    while (mcnt > 0) acc(2'd0, 1'b0, 1'b0, 16'hFE00, 16'h0, 4'h0, 2'd0, 1'b1);

    // bit op on lower half rejected
    acc(2'd2, 1'b0, 1'b0, 16'h10, 16'h0, 4'd15, 2'd1, 1'b0);
    chk("R8", "lower half oor", 16'(g_oor), 16'h1);
    acc(2'd2, 1'b0, 1'b0, 16'h10, 16'h0, 4'd4, 2'd2, 1'b0);
    rd_long(0, 16'h10);
    chk("R8", "lower half unchanged", g_rd, exp_std[16'h10]);

    // addresses outside both banks
    begin
      logic [15:0] bad [3];
      bad[0] = 16'h8000; bad[1] = 16'hF200; bad[2] = 16'hFC00;
      for (int j = 0; j < 3; j++) begin
        acc(2'd0, 1'b1, 1'b0, bad[j], 16'hDEAD, 4'h0, 2'd0, 1'b0);
        chk("R10", "oor write flag", 16'(g_oor), 16'h1);
        acc(2'd3, 1'b0, 1'b0, bad[j], 16'h0, 4'h0, 2'd0, 1'b0);
        chk("R10", "oor read zero", g_rd, 16'h0);
      end
      rd_long(0, 0);
      chk("R10", "std word 0 untouched", g_rd, exp_std[0]);
      rd_long(1, 0);
      chk("R10", "ext word 0 untouched", g_rd, exp_ext[0]);
    end

    // reset closes an open window
    ext_ld(3'd3, 1'b0);
    @(negedge clk);
    chk("R6", "window open before reset", 16'(ext_active), 16'h1);
    rst_n = 1'b0;
    #1;
    chk("R11", "window cleared on reset", 16'(ext_active), 16'h0);
    mcnt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    acc(2'd1, 1'b0, 1'b0, 16'h01, 16'h0, 4'h0, 2'd0, 1'b0);
    chk("R11", "window closed after release", 16'(g_act), 16'h0);
    chk("R11", "short goes std after reset", g_rd, exp_std[1]);

    @(negedge clk);
    req_valid = 1'b0;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule